// File: doc/BRIEF.md
# Protected Processor Status Register

This block is the core status byte of a small accumulator-style processor. It keeps three arithmetic flags (zero, digit carry, carry), two reset-cause bits (watchdog timeout and sleep/power-down) and three data-memory bank select bits. Any instruction may write the byte as an ordinary destination. The write is filtered as it lands. An arithmetic flag that the same instruction also updates takes the value from the flag logic instead of the written data. The reset-cause bits never take written data at all. As a result, the value read back after a write can differ from the value that was written.

The datapath drives one write strobe with the destination byte and, in the same cycle, a per-flag update enable with the computed flag values. Reset-cause hardware sets and clears the two cause bits through dedicated inputs. The current byte is always visible on the read port, and the bank bits drive the data-memory address logic directly. The block has no state machine: every bit is a register whose next value is chosen by fixed priority. All updates take effect on the rising clock edge after the inputs are presented.

Top module: `status_reg_core`

## Requirements
- R1: After reset (`rst_n` low), `rd_data` reads 8'h18: the bank bits and flags are 0, and both cause bits are 1.
- R2: The byte layout on `rd_data`, from bit 7 down to bit 0, is: indirect bank, bank bit 1, bank bit 0, timeout, power-down, zero, digit carry, carry. In `flg_upd_en` and `flg_val`, bit 2 is zero, bit 1 is digit carry and bit 0 is carry.
- R3: When `flg_upd_en[i]` is 1, flag i takes `flg_val[i]` on the next edge, whether or not `wr_en` is high.
- R4: When `wr_en` is 1 and `flg_upd_en[i]` is 0, flag i takes its bit of `wr_data`. Only the flags being updated are protected from the write.
- R5: A flag with neither a write nor an update keeps its value.
- R6: The timeout and power-down bits ignore `wr_en`/`wr_data` completely.
- R7: A cause bit becomes 1 when its set input is high. It becomes 0 when its clear input is high and its set input is low, so set wins. With neither input high it holds.
- R8: On `wr_en`, the three bank bits (7..5) take `wr_data[7:5]`; otherwise they hold.
- R9: `bank_sel` always equals `rd_data[6:5]`, and `ind_bank` always equals `rd_data[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| wr_en | input | 1 | Instruction writes the status byte |
| wr_data | input | 8 | Byte being written |
| flg_upd_en | input | 3 | Flags affected by this instruction (2 zero, 1 digit carry, 0 carry) |
| flg_val | input | 3 | New flag values from the flag logic |
| tmo_set | input | 1 | Set the timeout cause bit |
| tmo_clr | input | 1 | Clear the timeout cause bit |
| pwd_set | input | 1 | Set the power-down cause bit |
| pwd_clr | input | 1 | Clear the power-down cause bit |
| rd_data | output | 8 | Current status byte |
| bank_sel | output | 2 | Direct-addressing bank select |
| ind_bank | output | 1 | Indirect-addressing bank select |

## Verification
The assertions assume that every control input is a defined 0 or 1 at each rising edge, and that set and clear of a cause bit may arrive together. The priority rule resolves that case, so no constraint excludes it. The stimulus changes inputs only on the falling edge. It draws every input, including simultaneous set and clear, from a fixed-seed random source, so all overlap combinations of write, update and cause inputs occur. A directed prologue covers the cases where the written value differs from the value read back.

// File: rtl/status_pkg.sv
package status_pkg;
    localparam int STAT_W   = 8;
    localparam int FLAG_N   = 3;
    localparam int CAUSE_N  = 2;
    localparam int BANK_N   = 3;
    localparam int FLAG_LSB  = 0;
    localparam int CAUSE_LSB = FLAG_LSB + FLAG_N;
    localparam int BANK_LSB  = CAUSE_LSB + CAUSE_N;

    typedef struct packed {
        logic irp;
        logic rp1;
        logic rp0;
        logic tmo;
        logic pwd;
        logic zf;
        logic dcf;
        logic cyf;
    } status_t;
endpackage

// File: rtl/stat_flag_unit.sv
module stat_flag_unit #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    input  logic [N-1:0] upd_en,
    input  logic [N-1:0] upd_val,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flags[i] <= RST_VAL[i];
            else if (upd_en[i])  flags[i] <= upd_val[i];
            else if (wr_en)      flags[i] <= wr_bits[i];
        end

        AST_FLAG_LOGIC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            upd_en[i] |=> flags[i] == $past(upd_val[i])); // R3
        AST_FLAG_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !upd_en[i]) |=> flags[i] == $past(wr_bits[i])); // R4
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && !upd_en[i]) |=> $stable(flags[i])); // R5
    end
endmodule

// File: rtl/stat_cause_unit.sv
module stat_cause_unit #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] cause
);
    for (genvar i = 0; i < N; i++) begin : g_cause
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cause[i] <= 1'b1;
            else if (set_i[i])  cause[i] <= 1'b1;
            else if (clr_i[i])  cause[i] <= 1'b0;
        end

        AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> cause[i]); // R7
        AST_CAUSE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !cause[i]); // R7
        AST_CAUSE_NO_SW: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[i] && !clr_i[i]) |=> $stable(cause[i])); // R6
    end
endmodule

// File: rtl/stat_bank_unit.sv
module stat_bank_unit #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    output logic [N-1:0] bank
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bank <= '0;
        else if (wr_en) bank <= wr_bits;
    end

    AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bank == $past(wr_bits)); // R8
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank)); // R8
endmodule

// File: rtl/status_reg_core.sv
module status_reg_core
    import status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [FLAG_N-1:0] flg_upd_en,
    input  logic [FLAG_N-1:0] flg_val,
    input  logic              tmo_set,
    input  logic              tmo_clr,
    input  logic              pwd_set,
    input  logic              pwd_clr,
    output logic [STAT_W-1:0] rd_data,
    output logic [1:0]        bank_sel,
    output logic              ind_bank
);
    logic [FLAG_N-1:0]  flags_q;
    logic [CAUSE_N-1:0] cause_q;
    logic [BANK_N-1:0]  bank_q;
    status_t            stat;

    stat_flag_unit #(.N(FLAG_N), .RST_VAL('0)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bits (wr_data[FLAG_LSB +: FLAG_N]),
        .upd_en  (flg_upd_en),
        .upd_val (flg_val),
        .flags   (flags_q)
    );

    stat_cause_unit #(.N(CAUSE_N)) u_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i ({tmo_set, pwd_set}),
        .clr_i ({tmo_clr, pwd_clr}),
        .cause (cause_q)
    );

    stat_bank_unit #(.N(BANK_N)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bits (wr_data[BANK_LSB +: BANK_N]),
        .bank    (bank_q)
    );

    always_comb begin
        stat = status_t'({bank_q, cause_q, flags_q});
        rd_data  = stat;
        bank_sel = {stat.rp1, stat.rp0};
        ind_bank = stat.irp;
    end

    AST_BANK_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel == rd_data[6:5] && ind_bank == rd_data[7]); // R9
    AST_RESET_VALUE: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 8'h18 || rst_n)); // R1
endmodule

// File: tb/status_reg_core_tb.sv
module status_reg_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] flg_upd_en = '0;
    logic [2:0] flg_val = '0;
    logic       tmo_set = 1'b0, tmo_clr = 1'b0, pwd_set = 1'b0, pwd_clr = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] bank_sel;
    logic       ind_bank;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q;

    always #10 clk = ~clk;

    status_reg_core dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .flg_upd_en(flg_upd_en), .flg_val(flg_val),
        .tmo_set(tmo_set), .tmo_clr(tmo_clr), .pwd_set(pwd_set), .pwd_clr(pwd_clr),
        .rd_data(rd_data), .bank_sel(bank_sel), .ind_bank(ind_bank)
    );

    // Reference model built from the requirements
    function automatic logic [7:0] model_next(input logic [7:0] cur);
        logic [7:0] n = cur;
        for (int i = 0; i < 3; i++) begin
            if (flg_upd_en[i])  n[i] = flg_val[i];   // R3
            else if (wr_en)     n[i] = wr_data[i];   // R4, else hold R5
        end
        if (tmo_set) n[4] = 1'b1; else if (tmo_clr) n[4] = 1'b0;  // R6 R7
        if (pwd_set) n[3] = 1'b1; else if (pwd_clr) n[3] = 1'b0;
        if (wr_en) n[7:5] = wr_data[7:5];            // R8
        return n;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3/R4/R5 flags", {5'b0, rd_data[2:0]}, {5'b0, exp_q[2:0]});
        chk("R6/R7 cause", {6'b0, rd_data[4:3]}, {6'b0, exp_q[4:3]});
        chk("R8 bank bits", {5'b0, rd_data[7:5]}, {5'b0, exp_q[7:5]});
        chk("R9 bank ports", {5'b0, ind_bank, bank_sel}, {5'b0, rd_data[7:5]});
    endtask

    task automatic step(input logic we, input logic [7:0] d, input logic [2:0] ue,
                        input logic [2:0] uv, input logic [3:0] cs);
        wr_en = we; wr_data = d; flg_upd_en = ue; flg_val = uv;
        {tmo_set, tmo_clr, pwd_set, pwd_clr} = cs;
        exp_q = model_next(exp_q);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk("R1 reset value", rd_data, 8'h18);
        rst_n = 1'b1;
        exp_q = 8'h18;
        @(negedge clk);
        chk("R1 reset held", rd_data, 8'h18);
        // R4 R6 R8: plain write of all ones, cause bits unchanged
        step(1'b1, 8'hFF, 3'b000, 3'b000, 4'b0000);
        chk("R6 write ignored", rd_data, 8'hFF);
        // R6: write of zeros leaves cause bits at 1
        step(1'b1, 8'h00, 3'b000, 3'b000, 4'b0000);
        chk("R6 readback differs", rd_data, 8'h18);
        // R3: all flags updated, write loses
        step(1'b1, 8'hE7, 3'b111, 3'b010, 4'b0000);
        chk("R3 flag logic wins", rd_data, 8'hFA);
        // R4: partial update, only carry protected
        step(1'b1, 8'h06, 3'b001, 3'b001, 4'b0000);
        chk("R4 partial protect", rd_data, 8'h1F);
        // R3: update without write
        step(1'b0, 8'hFF, 3'b100, 3'b000, 4'b0000);
        chk("R3 update no write", rd_data, 8'h1B);
        // R7: clear both, then set and clear together
        step(1'b0, 8'h00, 3'b000, 3'b000, 4'b0101);
        chk("R7 clear", rd_data, 8'h03);
        step(1'b0, 8'h00, 3'b000, 3'b000, 4'b1111);
        chk("R7 set wins", rd_data, 8'h1B);
        // R5: idle cycle holds
        step(1'b0, 8'hA5, 3'b000, 3'b111, 4'b0000);
        chk("R5 hold", rd_data, 8'h1B);
        // R2/R9: bank field positions
        step(1'b1, 8'hA0, 3'b000, 3'b000, 4'b0000);
        chk("R2 layout", {6'b0, ind_bank, bank_sel[0]}, 8'h03);
        chk("R9 bank_sel", {6'b0, bank_sel}, 8'h01);
        for (int k = 0; k < 400; k++) begin
            step(1'($urandom), 8'($urandom), 3'($urandom), 3'($urandom), 4'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule